// File: doc/BRIEF.md
# AHB Transaction Activity Monitor

This block listens passively to a multi-master AHB bus and condenses each bus transaction into a fixed record of three 32-bit words (12 bytes). It follows the arbitration handshake and the address/control phases, and it samples the slave responses. It never drives any bus signal, and it does not depend on which masters or slaves are attached. Data-bus values are not captured.

A transaction opens when a NONSEQ transfer is accepted (HREADY high). It closes when the next NONSEQ or IDLE transfer is accepted, or in the first cycle of a non-OKAY response. For each master the block counts how many cycles that master requested the bus before it was granted. Every record carries a free-running cycle stamp taken when the transaction opened. Finished records wait in a small record FIFO and leave one word per beat on a valid/ready stream toward a host link. When the FIFO is full, new records are dropped and counted, so the bus is never stalled.

Top module: `ahb_txn_monitor`

## Requirements
- R1: Word 0 of a record is the address of the opening NONSEQ transfer. Word 2 is the stamp: the number of rising clock edges since reset release, counted before the edge that accepted that NONSEQ.
- R2: Word 1 packs these fields: master number (HMASTER) in bits 3:0, write flag in bit 8, HSIZE in bits 11:9 and HBURST in bits 14:12, all taken at the opening transfer.
- R3: Bits 19:15 of word 1 hold the beat count. The opening NONSEQ counts as one, and each SEQ accepted while the transaction is open adds one. BUSY transfers are ignored. The count saturates at 31.
- R4: Bits 22:20 of word 1 hold the end code. A transaction closed by an accepted NONSEQ or IDLE gets code 0. It gets code 4 instead when its burst type has a fixed length (SINGLE 1, 4-beat 4, 8-beat 8, 16-beat 16) and fewer beats were seen. Undefined-length INCR never takes code 4.
- R5: While a transaction is open, a cycle with HREADY low and HRESP ERROR, RETRY or SPLIT closes it at once, with end code 1, 2 or 3 respectively. The second response cycle has no further effect.
- R6: Bits 31:23 of word 1 hold the grant wait of the owning master. This is the number of cycles that master held its request without being granted with HREADY high, up to the grant that preceded the transaction. It saturates at 511 and is kept separately for each master.
- R7: Each record leaves as three beats in the order word 0, word 1, word 2, with the last flag set only on word 2. While valid is high and ready is low, the data and last flag hold steady.
- R8: A record that finishes while the FIFO holds its full depth of records (4 by default) is discarded. The overflow flag is then set and stays set until reset, and the drop counter adds one and saturates.
- R9: Bits 7:4 of word 1 hold the index of the lowest set bit of the slave-select vector at the opening transfer, or 0 when no bit is set.
- R10: After reset, the stream is not valid, the overflow flag is clear and the drop counter is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hbusreq | input | N_MASTERS | Per-master bus request |
| hgrant | input | N_MASTERS | Per-master bus grant |
| hmaster | input | 4 | Number of the master owning the address phase |
| hsel | input | N_SLAVES | Decoded slave selects |
| htrans | input | 2 | Transfer type |
| haddr | input | 32 | Address |
| hwrite | input | 1 | Write direction |
| hsize | input | 3 | Transfer size |
| hburst | input | 3 | Burst type |
| hready | input | 1 | Transfer ready |
| hresp | input | 2 | Slave response |
| rec_valid | output | 1 | Record word valid |
| rec_ready | input | 1 | Host ready for a word |
| rec_data | output | 32 | Record word |
| rec_last | output | 1 | Marks word 2 of a record |
| ovf_flag | output | 1 | Sticky overflow indication |
| drop_count | output | DROP_W | Saturating count of discarded records |

## Verification
Some properties are checked by assertions on every cycle. The output stream must keep its data stable while it is stalled, and the last flag may appear only on every third accepted beat. The overflow flag must be sticky, and the drop counter may move only after a push into a full FIFO. An accepted NONSEQ must open a transaction with one beat, an open transaction must close on the first cycle of an error response, and a master's wait count must clear after its grant. Other behaviour is shown only by the bench scenarios. These cover the exact packing of each field, the early-termination rule across burst types, both saturations, the choice of slave from several selects, back-to-back transactions, and which records survive an overflow.

// File: rtl/ahbmon_pkg.sv
package ahbmon_pkg;
  localparam int ADDR_W = 32;
  localparam int MST_W  = 4;
  localparam int SLV_W  = 4;
  localparam int BEAT_W = 5;
  localparam int END_W  = 3;
  localparam int WAIT_W = 9;
  localparam int TS_W   = 32;

  typedef enum logic [1:0] {
    TR_IDLE   = 2'b00,
    TR_BUSY   = 2'b01,
    TR_NONSEQ = 2'b10,
    TR_SEQ    = 2'b11
  } trans_e;

  localparam logic [END_W-1:0] END_OK    = 3'd0;
  localparam logic [END_W-1:0] END_ERROR = 3'd1;
  localparam logic [END_W-1:0] END_RETRY = 3'd2;
  localparam logic [END_W-1:0] END_SPLIT = 3'd3;
  localparam logic [END_W-1:0] END_EARLY = 3'd4;

  typedef struct packed {
    logic [TS_W-1:0]   stamp;
    logic [31:0]       info;
    logic [ADDR_W-1:0] addr;
  } rec_t;

  // Expected length of a burst type; 0 means open-ended
  function automatic logic [BEAT_W-1:0] burst_len(input logic [2:0] hb);
    case (hb)
      3'd0:       burst_len = 5'd1;
      3'd1:       burst_len = 5'd0;
      3'd2, 3'd3: burst_len = 5'd4;
      3'd4, 3'd5: burst_len = 5'd8;
      default:    burst_len = 5'd16;
    endcase
  endfunction

  function automatic logic [BEAT_W-1:0] beat_step(input logic [BEAT_W-1:0] b);
    beat_step = (b == '1) ? b : b + 1'b1;
  endfunction

  function automatic logic [WAIT_W-1:0] wait_step(input logic [WAIT_W-1:0] w);
    wait_step = (w == '1) ? w : w + 1'b1;
  endfunction

  function automatic logic [END_W-1:0] end_code(input logic by_resp,
                                                input logic [1:0] resp,
                                                input logic [BEAT_W-1:0] beats,
                                                input logic [2:0] hb);
    logic [BEAT_W-1:0] len;
    len = burst_len(hb);
    if (by_resp)
      end_code = (resp == 2'd1) ? END_ERROR : (resp == 2'd2) ? END_RETRY : END_SPLIT;
    else if (len != '0 && beats < len)
      end_code = END_EARLY;
    else
      end_code = END_OK;
  endfunction

  function automatic logic [31:0] pack_info(input logic [MST_W-1:0] mst,
                                            input logic [SLV_W-1:0] slv,
                                            input logic wr,
                                            input logic [2:0] sz,
                                            input logic [2:0] hb,
                                            input logic [BEAT_W-1:0] beats,
                                            input logic [END_W-1:0] ec,
                                            input logic [WAIT_W-1:0] wt);
    pack_info = {wt, ec, beats, hb, sz, wr, slv, mst};
  endfunction
endpackage

// File: rtl/ahbmon_wait_track.sv
module ahbmon_wait_track
  import ahbmon_pkg::*;
#(
  parameter int N_MASTERS = 4
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [N_MASTERS-1:0]             hbusreq,
  input  logic [N_MASTERS-1:0]             hgrant,
  input  logic                             hready,
  output logic [N_MASTERS-1:0][WAIT_W-1:0] wait_last
);
  for (genvar g = 0; g < N_MASTERS; g++) begin : g_mst
    logic [WAIT_W-1:0] run_q;
    logic [WAIT_W-1:0] last_q;
    logic              gnt_ok;

    assign gnt_ok       = hgrant[g] && hready;
    assign wait_last[g] = last_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        run_q  <= '0;
        last_q <= '0;
      end else if (gnt_ok) begin
        last_q <= run_q;
        run_q  <= '0;
      end else if (hbusreq[g]) begin
        run_q <= wait_step(run_q);
      end
    end

    AST_WAIT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      gnt_ok |=> (run_q == '0)); // R6
  end
endmodule

// File: rtl/ahbmon_txn_track.sv
module ahbmon_txn_track
  import ahbmon_pkg::*;
#(
  parameter int N_SLAVES = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          htrans,
  input  logic [ADDR_W-1:0]   haddr,
  input  logic                hwrite,
  input  logic [2:0]          hsize,
  input  logic [2:0]          hburst,
  input  logic                hready,
  input  logic [1:0]          hresp,
  input  logic [MST_W-1:0]    hmaster,
  input  logic [N_SLAVES-1:0] hsel,
  input  logic [WAIT_W-1:0]   wait_sel,
  input  logic [TS_W-1:0]     stamp,
  output logic                rec_push,
  output rec_t                rec
);
  trans_e            tr;
  logic              open_q;
  logic [ADDR_W-1:0] addr_q;
  logic [MST_W-1:0]  mst_q;
  logic [SLV_W-1:0]  slv_q;
  logic              wr_q;
  logic [2:0]        size_q, burst_q;
  logic [BEAT_W-1:0] beats_q;
  logic [WAIT_W-1:0] wait_q;
  logic [TS_W-1:0]   stamp_q;
  logic [SLV_W-1:0]  slv_idx;

  // Named events for assertions and readability
  logic start_evt, seq_evt, resp_close, norm_close;

  assign tr         = trans_e'(htrans);
  assign start_evt  = hready && (tr == TR_NONSEQ);
  assign seq_evt    = open_q && hready && (tr == TR_SEQ);
  assign resp_close = open_q && !hready && (hresp != 2'b00);
  assign norm_close = open_q && hready && (tr == TR_NONSEQ || tr == TR_IDLE);
  assign rec_push   = resp_close || norm_close;

  always_comb begin
    slv_idx = '0;
    for (int i = N_SLAVES - 1; i >= 0; i--)
      if (hsel[i]) slv_idx = SLV_W'(i);
  end

  always_comb begin
    rec.addr  = addr_q;
    rec.stamp = stamp_q;
    rec.info  = pack_info(mst_q, slv_q, wr_q, size_q, burst_q, beats_q,
                          end_code(resp_close, hresp, beats_q, burst_q), wait_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q  <= 1'b0;
      addr_q  <= '0;
      mst_q   <= '0;
      slv_q   <= '0;
      wr_q    <= 1'b0;
      size_q  <= '0;
      burst_q <= '0;
      beats_q <= '0;
      wait_q  <= '0;
      stamp_q <= '0;
    end else if (start_evt) begin
      open_q  <= 1'b1;
      addr_q  <= haddr;
      mst_q   <= hmaster;
      slv_q   <= slv_idx;
      wr_q    <= hwrite;
      size_q  <= hsize;
      burst_q <= hburst;
      beats_q <= BEAT_W'(1);
      wait_q  <= wait_sel;
      stamp_q <= stamp;
    end else if (rec_push) begin
      open_q <= 1'b0;
    end else if (seq_evt) begin
      beats_q <= beat_step(beats_q);
    end
  end

  AST_BEATS_START: assert property (@(posedge clk) disable iff (!rst_n)
    (hready && htrans == TR_NONSEQ) |=> (open_q && beats_q == BEAT_W'(1))); // R3
  AST_RESP_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    (open_q && !hready && hresp != 2'b00) |=> !open_q); // R5
endmodule

// File: rtl/ahbmon_rec_fifo.sv
module ahbmon_rec_fifo
  import ahbmon_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        push,
  input  rec_t        rec_in,
  output logic        full,
  output logic        rec_valid,
  input  logic        rec_ready,
  output logic [31:0] rec_data,
  output logic        rec_last
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  rec_t             mem [DEPTH];
  logic [PTR_W-1:0] wptr_q, rptr_q;
  logic [CNT_W-1:0] cnt_q;
  logic [1:0]       widx_q;
  logic             push_ok, pop;
  rec_t             head;

  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
    ptr_next = (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full      = (cnt_q == CNT_W'(DEPTH));
  assign push_ok   = push && !full;
  assign rec_valid = (cnt_q != '0);
  assign pop       = rec_valid && rec_ready && (widx_q == 2'd2);
  assign head      = mem[rptr_q];
  assign rec_last  = (widx_q == 2'd2);
  assign rec_data  = (widx_q == 2'd0) ? head.addr :
                     (widx_q == 2'd1) ? head.info : head.stamp;

  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr_q] <= rec_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
      widx_q <= '0;
    end else begin
      if (push_ok) wptr_q <= ptr_next(wptr_q);
      if (pop)     rptr_q <= ptr_next(rptr_q);
      if (push_ok && !pop)      cnt_q <= cnt_q + 1'b1;
      else if (!push_ok && pop) cnt_q <= cnt_q - 1'b1;
      if (rec_valid && rec_ready) widx_q <= (widx_q == 2'd2) ? 2'd0 : widx_q + 1'b1;
    end
  end
endmodule

// File: rtl/ahb_txn_monitor.sv
module ahb_txn_monitor
  import ahbmon_pkg::*;
#(
  parameter int N_MASTERS = 4,
  parameter int N_SLAVES  = 4,
  parameter int FIFO_RECS = 4,
  parameter int DROP_W    = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N_MASTERS-1:0] hbusreq,
  input  logic [N_MASTERS-1:0] hgrant,
  input  logic [3:0]           hmaster,
  input  logic [N_SLAVES-1:0]  hsel,
  input  logic [1:0]           htrans,
  input  logic [31:0]          haddr,
  input  logic                 hwrite,
  input  logic [2:0]           hsize,
  input  logic [2:0]           hburst,
  input  logic                 hready,
  input  logic [1:0]           hresp,
  output logic                 rec_valid,
  input  logic                 rec_ready,
  output logic [31:0]          rec_data,
  output logic                 rec_last,
  output logic                 ovf_flag,
  output logic [DROP_W-1:0]    drop_count
);
  logic [TS_W-1:0]                  stamp_q;
  logic [N_MASTERS-1:0][WAIT_W-1:0] wait_all;
  logic [WAIT_W-1:0]                wait_sel;
  logic                             rec_push, fifo_full, drop_evt;
  rec_t                             rec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stamp_q <= '0;
    else        stamp_q <= stamp_q + 1'b1;
  end

  ahbmon_wait_track #(.N_MASTERS(N_MASTERS)) u_wait (
    .clk(clk), .rst_n(rst_n), .hbusreq(hbusreq), .hgrant(hgrant),
    .hready(hready), .wait_last(wait_all)
  );

  always_comb begin
    wait_sel = '0;
    for (int i = 0; i < N_MASTERS; i++)
      if (hmaster == MST_W'(i)) wait_sel = wait_all[i];
  end

  ahbmon_txn_track #(.N_SLAVES(N_SLAVES)) u_track (
    .clk(clk), .rst_n(rst_n), .htrans(htrans), .haddr(haddr), .hwrite(hwrite),
    .hsize(hsize), .hburst(hburst), .hready(hready), .hresp(hresp),
    .hmaster(hmaster), .hsel(hsel), .wait_sel(wait_sel), .stamp(stamp_q),
    .rec_push(rec_push), .rec(rec)
  );

  ahbmon_rec_fifo #(.DEPTH(FIFO_RECS)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(rec_push), .rec_in(rec), .full(fifo_full),
    .rec_valid(rec_valid), .rec_ready(rec_ready), .rec_data(rec_data),
    .rec_last(rec_last)
  );

  assign drop_evt = rec_push && fifo_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_flag   <= 1'b0;
      drop_count <= '0;
    end else if (drop_evt) begin
      ovf_flag <= 1'b1;
      if (drop_count != '1) drop_count <= drop_count + 1'b1;
    end
  end

  // Beat position counter kept for the stream assertions
  logic [1:0] word_mod_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) word_mod_q <= '0;
    else if (rec_valid && rec_ready) word_mod_q <= (word_mod_q == 2'd2) ? 2'd0 : word_mod_q + 1'b1;
  end

  AST_LAST_THIRD: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_valid && rec_last) |-> (word_mod_q == 2'd2)); // R7
  AST_STREAM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_valid && !rec_ready) |=> (rec_valid && $stable(rec_data) && $stable(rec_last))); // R7
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_flag |=> ovf_flag); // R8
  AST_DROP_ONLY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(drop_count) |-> $past(fifo_full && rec_push)); // R8
endmodule

// File: tb/sim_ahb_txn_monitor.sv
module sim_ahb_txn_monitor;
  import ahbmon_pkg::*;
  localparam int CLK_PERIOD = 10;
  localparam int NM = 4;
  localparam int NS = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NM-1:0] hbusreq = '0;
  logic [NM-1:0] hgrant = 4'b0001;
  logic [3:0]    hmaster = '0;
  logic [NS-1:0] hsel = '0;
  logic [1:0]    htrans = TR_IDLE;
  logic [31:0]   haddr = '0;
  logic          hwrite = 1'b0;
  logic [2:0]    hsize = '0;
  logic [2:0]    hburst = '0;
  logic          hready = 1'b1;
  logic [1:0]    hresp = '0;
  logic          rec_valid, rec_last, ovf_flag;
  logic          rec_ready = 1'b0;
  logic [31:0]   rec_data;
  logic [15:0]   drop_count;

  ahb_txn_monitor u0 (
    .clk(clk), .rst_n(rst_n), .hbusreq(hbusreq), .hgrant(hgrant), .hmaster(hmaster),
    .hsel(hsel), .htrans(htrans), .haddr(haddr), .hwrite(hwrite), .hsize(hsize),
    .hburst(hburst), .hready(hready), .hresp(hresp), .rec_valid(rec_valid),
    .rec_ready(rec_ready), .rec_data(rec_data), .rec_last(rec_last),
    .ovf_flag(ovf_flag), .drop_count(drop_count)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int unsigned cyc = 0;
  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [95:0] expq[$];
  string       tagq[$];

  int ready_mode = 0;
  logic [7:0] lfsr = 8'hA5;
  always @(negedge clk) begin
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    rec_ready <= (ready_mode == 0) ? 1'b1 : (ready_mode == 1) ? lfsr[0] : 1'b0;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Scoreboard monitor: samples 3 time units after each falling edge
  logic [31:0] got [3];
  int  wi = 0;
  bit  hold_pend = 1'b0;
  logic [31:0] hold_data;
  always begin
    @(negedge clk);
    #3;
    if (rst_n) begin
      if (hold_pend) begin
        chk(rec_valid && rec_data == hold_data, "R7", "stalled word changed", rec_data, hold_data);
        hold_pend = 1'b0;
      end
      if (rec_valid && !rec_ready) begin
        hold_pend = 1'b1;
        hold_data = rec_data;
      end
      if (rec_valid && rec_ready) begin
        got[wi] = rec_data;
        chk(rec_last == (wi == 2), "R7", "last flag", 32'(rec_last), 32'(wi == 2));
        if (wi == 2) begin
          wi = 0;
          if (expq.size() == 0) begin
            chk(1'b0, "R7", "unexpected record", got[0], 32'h0);
          end else begin
            logic [95:0] e;
            string t;
            e = expq.pop_front();
            t = tagq.pop_front();
            chk(got[0] == e[31:0], "R1", "word0 address", got[0], e[31:0]);
            chk(got[1] == e[63:32], t, "word1 fields", got[1], e[63:32]);
            chk(got[2] == e[95:64], "R1", "word2 stamp", got[2], e[95:64]);
          end
        end else begin
          wi++;
        end
      end
    end
  end

  function automatic int exp_len(input logic [2:0] b);
    if (b == 3'd0) return 1;
    if (b == 3'd1) return 0;
    if (b <= 3'd3) return 4;
    if (b <= 3'd5) return 8;
    return 16;
  endfunction

  function automatic logic [3:0] lowest(input logic [NS-1:0] s);
    for (int i = 0; i < NS; i++) if (s[i]) return 4'(i);
    return 4'd0;
  endfunction

  // Driver: runs one transaction and pushes the record it expects.
  // endk: 0 close by IDLE, 1..3 close by that response, 5 left open for the next NONSEQ
  task automatic txn(input int m, input int waitc, input bit do_grant,
                     input logic [31:0] addr, input logic [NS-1:0] sel, input bit wr,
                     input logic [2:0] size, input logic [2:0] burst, input int nseq,
                     input bit busy, input int endk, input bit keep, input string tag);
    int unsigned ts;
    int beats;
    int bl;
    logic [2:0] ec;
    logic [8:0] wv;
    wv = '0;
    if (do_grant) begin
      repeat (waitc) begin
        @(negedge clk);
        hbusreq = '0; hbusreq[m] = 1'b1; hgrant = '0;
        htrans = TR_IDLE; hready = 1'b1; hresp = '0;
      end
      @(negedge clk);
      hbusreq = '0; hbusreq[m] = 1'b1; hgrant = '0; hgrant[m] = 1'b1;
      htrans = TR_IDLE; hready = 1'b1; hresp = '0;
      wv = (waitc > 511) ? 9'd511 : 9'(waitc);
    end
    @(negedge clk);
    hbusreq = '0; hmaster = 4'(m); htrans = TR_NONSEQ; haddr = addr; hsel = sel;
    hwrite = wr; hsize = size; hburst = burst; hready = 1'b1; hresp = '0;
    ts = cyc;
    for (int i = 0; i < nseq; i++) begin
      if (busy) begin @(negedge clk); htrans = TR_BUSY; end
      @(negedge clk); htrans = TR_SEQ; haddr = haddr + 4;
    end
    beats = (nseq + 1 > 31) ? 31 : nseq + 1;
    bl = exp_len(burst);
    ec = (bl != 0 && beats < bl) ? 3'd4 : 3'd0;
    if (endk == 0) begin
      @(negedge clk); htrans = TR_IDLE;
    end else if (endk >= 1 && endk <= 3) begin
      @(negedge clk); htrans = TR_IDLE; hready = 1'b0; hresp = 2'(endk);
      @(negedge clk); hready = 1'b1;
      @(negedge clk); hresp = '0;
      ec = 3'(endk);
    end
    if (keep) begin
      expq.push_back({ts, {wv, ec, 5'(beats), burst, size, wr, lowest(sel), 4'(m)}, addr});
      tagq.push_back(tag);
    end
  endtask

  task automatic drain(input int limit);
    int n;
    n = 0;
    while ((expq.size() != 0 || rec_valid) && n < limit) begin
      @(negedge clk);
      n++;
    end
    @(negedge clk);
    #4;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=0", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #4;
    chk(!rec_valid, "R10", "valid after reset", 32'(rec_valid), 32'h0);
    chk(!ovf_flag, "R10", "overflow after reset", 32'(ovf_flag), 32'h0);
    chk(drop_count == 0, "R10", "drop count after reset", 32'(drop_count), 32'h0);

    // R1 R2 R3 R9: complete 4-beat write, master 1 waited 3 cycles
    txn(1, 3, 1, 32'h1000_0040, 4'b0100, 1'b1, 3'd2, 3'd3, 3, 1'b0, 0, 1'b1, "R2");
    // R3 R4: 8-beat read cut short after 3 beats, BUSY between beats, no select
    txn(2, 0, 1, 32'h2000_0100, 4'b0000, 1'b0, 3'd1, 3'd5, 2, 1'b1, 0, 1'b1, "R4");
    ready_mode = 1;
    // R5: error, retry and split responses
    txn(3, 2, 1, 32'h3000_0000, 4'b1000, 1'b1, 3'd0, 3'd0, 0, 1'b0, 1, 1'b1, "R5");
    txn(0, 1, 1, 32'h3000_0010, 4'b0010, 1'b0, 3'd2, 3'd1, 1, 1'b0, 2, 1'b1, "R5");
    txn(1, 0, 1, 32'h3000_0020, 4'b0001, 1'b1, 3'd2, 3'd7, 4, 1'b0, 3, 1'b1, "R5");
    // R3: undefined-length burst saturates the beat count, never early
    txn(2, 0, 1, 32'h4000_0000, 4'b0001, 1'b0, 3'd2, 3'd1, 40, 1'b0, 0, 1'b1, "R3");
    // R6: long wait saturates
    txn(3, 520, 1, 32'h5000_0000, 4'b0001, 1'b1, 3'd0, 3'd0, 0, 1'b0, 0, 1'b1, "R6");
    // R9: several selects set, lowest wins
    txn(0, 5, 1, 32'h6000_0000, 4'b1010, 1'b0, 3'd0, 3'd0, 0, 1'b0, 0, 1'b1, "R9");
    // R4: back-to-back NONSEQ closes the first; 16-beat burst complete
    txn(1, 2, 1, 32'h7000_0000, 4'b0100, 1'b1, 3'd2, 3'd7, 15, 1'b0, 5, 1'b1, "R4");
    txn(1, 0, 0, 32'h7000_1000, 4'b0100, 1'b1, 3'd0, 3'd2, 1, 1'b0, 0, 1'b1, "R4");
    ready_mode = 0;
    drain(3000);
    chk(expq.size() == 0, "R7", "records outstanding before overflow", expq.size(), 32'h0);

    // R8: overflow with host stalled
    ready_mode = 2;
    @(negedge clk);
    for (int k = 0; k < 6; k++)
      txn(k % 4, 0, 1, 32'h8000_0000 + 32'(k * 16), 4'b0001, 1'b0, 3'd2, 3'd0, 0, 1'b0, 0, k < 4, "R8");
    repeat (2) @(negedge clk);
    #4;
    chk(drop_count == 2, "R8", "drop count", 32'(drop_count), 32'd2);
    chk(ovf_flag, "R8", "overflow set", 32'(ovf_flag), 32'h1);
    chk(rec_valid, "R8", "records still held", 32'(rec_valid), 32'h1);
    ready_mode = 0;
    drain(3000);
    chk(ovf_flag, "R8", "overflow sticky after drain", 32'(ovf_flag), 32'h1);
    chk(drop_count == 2, "R8", "drop count after drain", 32'(drop_count), 32'd2);
    chk(expq.size() == 0, "R7", "records outstanding at end", expq.size(), 32'h0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule